// File: doc/BRIEF.md
# PFC Enable Sequencing Supervisor

This block decides, cycle by cycle, whether a downstream power-factor-correction stage may run. It watches digital status from a PWM controller: whether the controller supply is up, whether the peak-current limit is active, whether the controller is skipping cycles, and whether a latching protection fault has been raised. From these it drives a single PFC enable and three mutually exclusive indications that say why the enable is off.

The enable is never granted before the PWM side is running and regulating. After power-up it waits until the peak-current flag first drops. Two persistence timers, each set in clock ticks by a parameter, guard the slow decisions. A peak-current condition that lasts a full fault window puts the block into fault burst. Skip activity that lasts a full standby window confirms standby. Leaving standby takes effect one cycle after the skip activity stops. A latching fault overrides everything until it is cleared.

Every decision is taken from registered state, so each output reflects the inputs sampled at the previous rising clock edge. Reset is synchronous and active high.

Top module: `pfc_enable_supervisor`

## Requirements
- R1: While `rst` is sampled high, all state is cleared. On the cycle after, `pfc_en`, `burst_mode`, `standby` and `latched` are all 0, and the block is in power-up hold.
- R2: After reset, or after supply loss, `pfc_en` stays 0 until an edge samples `supply_ok`=1 with `err_flag`=0. With no higher-priority condition, `pfc_en` is 1 from that edge on.
- R3: `standby` becomes 1 and `pfc_en` becomes 0 right after the STBY_TICKS-th consecutive edge that samples `skip_active`=1 with `supply_ok`=1. A shorter run followed by one sample without skip restarts the count and confirms nothing.
- R4: The first edge that samples `skip_active`=0 clears `standby`. If no other condition holds, it sets `pfc_en` to 1 on that same edge.
- R5: `burst_mode` becomes 1 and `pfc_en` becomes 0 right after the FAULT_TICKS-th consecutive edge that samples `err_flag`=1 with `supply_ok`=1. A shorter run records no fault.
- R6: Fault burst persists while `err_flag` stays 1, even through supply loss. The first edge that samples `err_flag`=0 ends it, and `pfc_en` returns to 1 on that edge when nothing of higher priority holds.
- R7: An edge that samples `latch_req`=1 sets `latched` and forces `pfc_en` to 0. The latch holds until an edge samples `latch_clr`=1 with `latch_req`=0. A request and a clear in the same cycle leave the latch set.
- R8: Priority from highest to lowest is latch-off, fault burst, power-up hold, confirmed standby, run. At most one of `latched`, `burst_mode`, `standby`, `pfc_en` is 1 in any cycle.
- R9: An edge that samples `supply_ok`=0 forces `pfc_en` to 0 on the following cycle. It re-arms the power-up hold and restarts both persistence counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | PWM controller supply is up and switching |
| err_flag | input | 1 | Peak-current limit is active |
| skip_active | input | 1 | PWM controller is skipping cycles |
| latch_req | input | 1 | Latching protection fault request |
| latch_clr | input | 1 | Clears the latched fault |
| pfc_en | output | 1 | Power-factor stage may run |
| burst_mode | output | 1 | Persistent overcurrent, fault burst active |
| standby | output | 1 | Standby confirmed |
| latched | output | 1 | Latched-off fault active |

## Verification
Some properties hold on every cycle and are checked there. The four outputs are mutually exclusive. Supply loss always removes the enable. A latch request always sets the latch, and the latch holds until it is cleared. Standby and burst exits follow their clearing sample. An independent run counter shows that standby and burst are entered only after a full window of qualifying samples. The bench scenarios are needed for the exact edge of each timer window (one sample short against exactly enough), for the power-up hold releasing on the first clear error sample, for request-over-clear precedence, and for burst surviving a supply dropout. All of these are compared against a model of the requirements under long random sequences.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;

    typedef enum logic [2:0] {
        MODE_HOLD    = 3'd0,
        MODE_RUN     = 3'd1,
        MODE_STANDBY = 3'd2,
        MODE_BURST   = 3'd3,
        MODE_LATCHED = 3'd4
    } pfc_mode_t;

    // Registered supervisor state feeding the arbiter
    typedef struct packed {
        logic latched;
        logic burst;
        logic regulated;
        logic standby;
    } pfc_state_t;

    // Decoded outputs
    typedef struct packed {
        logic pfc_en;
        logic burst_mode;
        logic standby;
        logic latched;
    } pfc_out_t;

    // Fixed priority: latch-off, burst, power-up hold, standby, run
    function automatic pfc_mode_t pick_mode(input pfc_state_t s);
        pfc_mode_t m;
        if (s.latched)         m = MODE_LATCHED;
        else if (s.burst)      m = MODE_BURST;
        else if (!s.regulated) m = MODE_HOLD;
        else if (s.standby)    m = MODE_STANDBY;
        else                   m = MODE_RUN;
        return m;
    endfunction

    function automatic pfc_out_t decode_mode(input pfc_mode_t m);
        pfc_out_t o;
        o.pfc_en     = (m == MODE_RUN);
        o.burst_mode = (m == MODE_BURST);
        o.standby    = (m == MODE_STANDBY);
        o.latched    = (m == MODE_LATCHED);
        return o;
    endfunction

endpackage

// File: rtl/pfc_persist_timer.sv
// Counts consecutive qualifying samples; pulses fire on the LIMIT-th one.
module pfc_persist_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic fire
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_TOP  = W'(LIMIT);
    localparam logic [W-1:0] LIM_LAST = W'(LIMIT - 1);

    logic [W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !cond) begin
            run_cnt <= '0;
        end else if (run_cnt != LIM_TOP) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign fire = cond && (run_cnt == LIM_LAST);

endmodule

// File: rtl/pfc_state_regs.sv
// Holds the latch, regulation, burst and standby state bits.
module pfc_state_regs
    import pfc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       err_flag,
    input  logic       skip_active,
    input  logic       latch_req,
    input  logic       latch_clr,
    input  logic       fault_fire,
    input  logic       stby_fire,
    output pfc_state_t state
);
    pfc_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            // latch: request wins over clear
            if (latch_req)      st_q.latched <= 1'b1;
            else if (latch_clr) st_q.latched <= 1'b0;

            // regulation reached once the error flag drops with supply up
            if (!supply_ok)     st_q.regulated <= 1'b0;
            else if (!err_flag) st_q.regulated <= 1'b1;

            // burst ends on the first clear error sample only
            if (!err_flag)       st_q.burst <= 1'b0;
            else if (fault_fire) st_q.burst <= 1'b1;

            // standby leaves as soon as skip qualification is lost
            if (!(skip_active && supply_ok)) st_q.standby <= 1'b0;
            else if (stby_fire)              st_q.standby <= 1'b1;
        end
    end

    assign state = st_q;

endmodule

// File: rtl/pfc_mode_arbiter.sv
module pfc_mode_arbiter
    import pfc_seq_pkg::*;
(
    input  pfc_state_t state,
    output pfc_mode_t  mode,
    output pfc_out_t   outs
);
    always_comb begin
        mode = pick_mode(state);
        outs = decode_mode(mode);
    end
endmodule

// File: rtl/pfc_enable_supervisor.sv
module pfc_enable_supervisor
    import pfc_seq_pkg::*;
#(
    parameter int FAULT_TICKS = 5_000_000,
    parameter int STBY_TICKS  = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic err_flag,
    input  logic skip_active,
    input  logic latch_req,
    input  logic latch_clr,
    output logic pfc_en,
    output logic burst_mode,
    output logic standby,
    output logic latched
);
    localparam int NUM_TIMERS = 2;
    localparam int T_FAULT    = 0;
    localparam int T_STBY     = 1;

    logic [NUM_TIMERS-1:0] t_cond;
    logic [NUM_TIMERS-1:0] t_fire;
    pfc_state_t            state;
    pfc_mode_t             mode;
    pfc_out_t              outs;

    assign t_cond[T_FAULT] = supply_ok && err_flag;
    assign t_cond[T_STBY]  = supply_ok && skip_active;

    generate
        for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_timer
            localparam int LIM = (g == T_FAULT) ? FAULT_TICKS : STBY_TICKS;
            pfc_persist_timer #(.LIMIT(LIM)) u_timer (
                .clk  (clk),
                .rst  (rst),
                .cond (t_cond[g]),
                .fire (t_fire[g])
            );
        end
    endgenerate

    pfc_state_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .supply_ok   (supply_ok),
        .err_flag    (err_flag),
        .skip_active (skip_active),
        .latch_req   (latch_req),
        .latch_clr   (latch_clr),
        .fault_fire  (t_fire[T_FAULT]),
        .stby_fire   (t_fire[T_STBY]),
        .state       (state)
    );

    pfc_mode_arbiter u_arb (
        .state (state),
        .mode  (mode),
        .outs  (outs)
    );

    assign pfc_en     = outs.pfc_en;
    assign burst_mode = outs.burst_mode;
    assign standby    = outs.standby;
    assign latched    = outs.latched;

endmodule

// File: rtl/pfc_enable_supervisor_chk.sv
module pfc_enable_supervisor_chk #(
    parameter int FAULT_TICKS = 5_000_000,
    parameter int STBY_TICKS  = 5_000_000
) (
    input logic clk,
    input logic rst,
    input logic supply_ok,
    input logic err_flag,
    input logic skip_active,
    input logic latch_req,
    input logic latch_clr,
    input logic pfc_en,
    input logic burst_mode,
    input logic standby,
    input logic latched
);
    localparam int EW = $clog2(FAULT_TICKS + 1);
    localparam int SW = $clog2(STBY_TICKS + 1);
    localparam logic [EW-1:0] E_TOP = EW'(FAULT_TICKS);
    localparam logic [SW-1:0] S_TOP = SW'(STBY_TICKS);

    logic [EW-1:0] e_seen;
    logic [SW-1:0] s_seen;

    always_ff @(posedge clk) begin
        if (rst || !(supply_ok && err_flag)) e_seen <= '0;
        else if (e_seen != E_TOP)            e_seen <= e_seen + 1'b1;
        if (rst || !(supply_ok && skip_active)) s_seen <= '0;
        else if (s_seen != S_TOP)               s_seen <= s_seen + 1'b1;
    end

    a_r1_reset_off: assert property (@(posedge clk)
        rst |=> (!pfc_en && !burst_mode && !standby && !latched));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pfc_en, burst_mode, standby, latched}));

    a_r9_no_supply_no_pfc: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !pfc_en);

    a_r7_latch_sets: assert property (@(posedge clk) disable iff (rst)
        latch_req |=> latched);

    a_r7_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (latched && !latch_clr) |=> latched);

    a_r4_standby_exit: assert property (@(posedge clk) disable iff (rst)
        (standby && !skip_active) |=> !standby);

    a_r6_burst_exit: assert property (@(posedge clk) disable iff (rst)
        (burst_mode && !err_flag) |=> !burst_mode);

    a_r3_standby_window: assert property (@(posedge clk) disable iff (rst)
        standby |-> (s_seen == S_TOP));

    a_r5_burst_window: assert property (@(posedge clk) disable iff (rst)
        ($rose(burst_mode) && !$past(latched)) |-> (e_seen == E_TOP));

endmodule

bind pfc_enable_supervisor pfc_enable_supervisor_chk #(
    .FAULT_TICKS (FAULT_TICKS),
    .STBY_TICKS  (STBY_TICKS)
) u_chk (.*);

// File: tb/test_pfc_enable_supervisor.sv
module test_pfc_enable_supervisor;
    localparam int F = 6;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst, supply_ok, err_flag, skip_active, latch_req, latch_clr;
    logic pfc_en, burst_mode, standby, latched;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    bit m_lat, m_reg, m_burst, m_stby;
    int m_erun, m_srun;

    always #10 clk = ~clk;

    pfc_enable_supervisor #(.FAULT_TICKS(F), .STBY_TICKS(S)) i_pfc_enable_supervisor (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .err_flag(err_flag),
        .skip_active(skip_active), .latch_req(latch_req), .latch_clr(latch_clr),
        .pfc_en(pfc_en), .burst_mode(burst_mode), .standby(standby), .latched(latched)
    );

    function automatic logic [3:0] exp_outs();
        // {pfc_en, burst_mode, standby, latched} by priority
        if (m_lat)        return 4'b0001;
        else if (m_burst) return 4'b0100;
        else if (!m_reg)  return 4'b0000;
        else if (m_stby)  return 4'b0010;
        else              return 4'b1000;
    endfunction

    function automatic string exp_tag();
        if (m_lat)        return "R7";
        else if (m_burst) return "R5";
        else if (!m_reg)  return "R2";
        else if (m_stby)  return "R3";
        else              return "R4";
    endfunction

    task automatic model_step();
        if (rst) begin
            m_lat = 0; m_reg = 0; m_burst = 0; m_stby = 0; m_erun = 0; m_srun = 0;
        end else begin
            if (latch_req)      m_lat = 1;
            else if (latch_clr) m_lat = 0;
            if (!supply_ok)     m_reg = 0;
            else if (!err_flag) m_reg = 1;
            m_erun = (supply_ok && err_flag) ? ((m_erun < F) ? m_erun + 1 : F) : 0;
            m_srun = (supply_ok && skip_active) ? ((m_srun < S) ? m_srun + 1 : S) : 0;
            m_burst = !err_flag ? 1'b0 : (m_burst || (m_erun == F));
            m_stby  = (m_srun == S);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic [3:0] e;
        @(posedge clk);
        model_step();
        @(negedge clk);
        e = exp_outs();
        total++;
        if ({pfc_en, burst_mode, standby, latched} !== e) begin
            bad++;
            $display("FAIL %s model: actual=%b expected=%b at %0t", exp_tag(),
                     {pfc_en, burst_mode, standby, latched}, e, $time);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1239));
        rst = 1; supply_ok = 0; err_flag = 1; skip_active = 0; latch_req = 0; latch_clr = 0;
        ticks(2);
        rst = 0;
        // R1: reset state
        check_bit("R1 pfc_en", pfc_en, 0);
        check_bit("R1 latched", latched, 0);

        // R2: power-up hold while error flag stays high
        supply_ok = 1; err_flag = 1;
        ticks(3);
        check_bit("R2 hold", pfc_en, 0);
        err_flag = 0;
        tick();
        check_bit("R2 release", pfc_en, 1);

        // R3: one short of the window, then restart
        skip_active = 1; ticks(S - 1);
        check_bit("R3 short run", standby, 0);
        skip_active = 0; tick();
        skip_active = 1; ticks(S - 1);
        check_bit("R3 restarted", standby, 0);
        tick();
        check_bit("R3 confirmed", standby, 1);
        check_bit("R3 pfc off", pfc_en, 0);

        // R4: immediate exit
        skip_active = 0; tick();
        check_bit("R4 exit standby", standby, 0);
        check_bit("R4 pfc on", pfc_en, 1);

        // R5: short error run leaves no fault; full run enters burst
        err_flag = 1; ticks(F - 1);
        check_bit("R5 short run", burst_mode, 0);
        err_flag = 0; tick();
        err_flag = 1; ticks(F);
        check_bit("R5 burst", burst_mode, 1);
        check_bit("R5 pfc off", pfc_en, 0);

        // R6: burst survives supply dropout, ends on clear error
        supply_ok = 0; ticks(2);
        check_bit("R6 burst kept", burst_mode, 1);
        supply_ok = 1; err_flag = 0; tick();
        check_bit("R6 burst end", burst_mode, 0);
        check_bit("R6 pfc on", pfc_en, 1);

        // R7: request beats clear in the same cycle
        latch_req = 1; latch_clr = 1; tick();
        latch_req = 0; latch_clr = 0;
        check_bit("R7 req wins", latched, 1);
        // R8: latch outranks burst
        err_flag = 1; ticks(F + 2);
        check_bit("R8 latch over burst", latched, 1);
        check_bit("R8 burst hidden", burst_mode, 0);
        latch_clr = 1; tick(); latch_clr = 0;
        check_bit("R7 cleared", latched, 0);
        check_bit("R8 burst shows", burst_mode, 1);
        err_flag = 0; tick();

        // R9: supply loss removes enable and re-arms hold
        supply_ok = 0; tick();
        check_bit("R9 no supply", pfc_en, 0);
        supply_ok = 1; err_flag = 1; ticks(2);
        check_bit("R9 hold re-armed", pfc_en, 0);
        err_flag = 0; tick();
        check_bit("R9 release", pfc_en, 1);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0)   err_flag    = ~err_flag;
            if ($urandom_range(5) == 0)   skip_active = ~skip_active;
            if ($urandom_range(99) == 0)  supply_ok   = 1'b0;
            else if ($urandom_range(9) == 0) supply_ok = 1'b1;
            latch_req = ($urandom_range(99) == 0);
            latch_clr = ($urandom_range(15) == 0);
            rst       = ($urandom_range(999) == 0);
            tick();
        end
        finish_run();
    end
endmodule